// File: doc/BRIEF.md
# LED Chain Grayscale Transmitter

This block is the host-side serializer for a daisy chain of single-wire PWM LED drivers. It keeps a local copy of three 8-bit grayscale values for each of `N_DEV` devices. Software-side logic writes these values through a simple load port while the block is idle. A `start` pulse then sends one complete update to the whole chain.

The devices are served in chain order, starting with device 0, the one wired nearest the controller. Each device gets a 32-bit word: a fixed write-command byte and then its three grayscale bytes, sent most significant bit first. A short low gap separates one device's word from the next. After the last device the line stays low for a longer gap, which makes every device in the chain latch its new values at the same moment. Then `done` pulses.

Every update rewrites all devices, even if only one value has changed. The bit period in clocks, the chain length and both gap lengths are parameters.

Top module: `ledchain_tx`

## Requirements
- R1: After reset, `sdo`, `busy` and `done` are low and every stored grayscale value is 0x00.
- R2: Each device word is 32 bits and is sent MSB first. Bits 31..24 hold the command byte 0x3A, bits 23..16 hold channel 2, bits 15..8 hold channel 1 and bits 7..0 hold channel 0.
- R3: Every bit lasts `BIT_CLKS` clocks and begins with a high pulse of `BIT_CLKS/8` clocks. A 1 bit adds a second pulse of the same width that starts `BIT_CLKS/4` clocks after the bit began. The line is low at all other times.
- R4: Device words go out in ascending index order, from device 0 to device `N_DEV-1`.
- R5: Between two device words the line stays low for an end-of-word gap of `EOS_BITS` (4) bit periods. Across that boundary, consecutive bit-start edges are therefore 5 bit periods apart.
- R6: After the last bit of the last device the line stays low for `LATCH_BITS` (8) bit periods. `done` is then high for exactly one clock, `9*BIT_CLKS-1` clocks after the last bit's leading edge, and `busy` falls in that same clock.
- R7: When `start` is sampled while the block is idle, `busy` rises on that edge. The first bit's leading edge appears on `sdo` one clock later.
- R8: A `start` pulse while `busy` is high is ignored. The transfer in progress is neither restarted nor lengthened, and `done` pulses only once.
- R9: When idle, `ld_we` writes `ld_val` into device `ld_dev` at channel `ld_ch`, where 0, 1 and 2 select channels 0, 1 and 2. The value `ld_ch = 3` writes nothing. Loads made while `busy` is high are ignored.
- R10: Every `start` sends all `N_DEV` words, `32*N_DEV` bits in total, whether or not any value changed since the previous update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Grayscale write strobe |
| ld_dev | input | DEV_W | Device index for the write |
| ld_ch | input | 2 | Channel select (0..2; 3 writes nothing) |
| ld_val | input | 8 | Grayscale value to store |
| start | input | 1 | Begin a full chain update |
| busy | output | 1 | High while an update is in progress |
| done | output | 1 | One-clock pulse when the latch gap ends |
| sdo | output | 1 | Single-wire serial line to the first device |

## Verification
A wrong sequencer state or counter shows up on `sdo` within one bit period. A bad shift-register bit, a bad command byte or a stuck bit counter changes the decoded 32-bit word. An off-by-one in the cycle counter moves the bit-start edges away from multiples of `BIT_CLKS`. A wrong device index or gap counter shows within one word: the gap spacing changes, the bytes come from the wrong device, or the `done` pulse lands at the wrong distance from the last leading edge. Because every update resends the whole chain, a corrupted stored value is visible in the very next frame.

// File: rtl/ledchain_pkg.sv
package ledchain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_EOS   = 2'd2,
    ST_LATCH = 2'd3
  } seq_state_t;

  localparam logic [7:0] CMD_BYTE = 8'h3A;
  localparam int         PKT_BITS = 32;
  localparam int         GS_BITS  = 24;
endpackage

// File: rtl/ledchain_gs_store.sv
module ledchain_gs_store #(
  parameter  int N_DEV = 4,
  localparam int DEV_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DEV_W-1:0] wr_dev,
  input  logic [1:0]       wr_ch,
  input  logic [7:0]       wr_val,
  input  logic [DEV_W-1:0] rd_dev,
  output logic [23:0]      rd_word
);
  localparam int N_CH = 3;

  logic [N_DEV*N_CH*8-1:0] gs_flat;

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic       hit;
      logic [7:0] byte_q;
      assign hit = we && (wr_dev == DEV_W'(d)) && (wr_ch == 2'(c));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          byte_q <= 8'h00;
        end else if (hit) begin
          byte_q <= wr_val;
        end
      end
      assign gs_flat[(d*N_CH+c)*8 +: 8] = byte_q;
    end
  end

  // word layout {ch2, ch1, ch0}; out-of-range index reads zero
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_DEV; i++) begin
      if (rd_dev == DEV_W'(i)) rd_word = gs_flat[i*24 +: 24];
    end
  end
endmodule

// File: rtl/ledchain_bit_shaper.sv
module ledchain_bit_shaper #(
  parameter  int BIT_CLKS = 16,
  localparam int CW       = $clog2(BIT_CLKS)
) (
  input  logic          sending,
  input  logic [CW-1:0] cyc,
  input  logic          bit_val,
  output logic          line
);
  localparam int PW_RAW = BIT_CLKS / 8;
  localparam int PW     = (PW_RAW < 1) ? 1 : PW_RAW;
  localparam int QTR    = BIT_CLKS / 4;

  localparam logic [CW-1:0] PW_C   = CW'(PW);
  localparam logic [CW-1:0] Q_C    = CW'(QTR);
  localparam logic [CW-1:0] Q_END  = CW'(QTR + PW);

  logic lead_pulse;
  logic data_pulse;

  assign lead_pulse = (cyc < PW_C);
  assign data_pulse = bit_val && (cyc >= Q_C) && (cyc < Q_END);
  assign line       = sending && (lead_pulse || data_pulse);
endmodule

// File: rtl/ledchain_seq.sv
module ledchain_seq
  import ledchain_pkg::*;
#(
  parameter  int N_DEV      = 4,
  parameter  int BIT_CLKS   = 16,
  parameter  int EOS_BITS   = 4,
  parameter  int LATCH_BITS = 8,
  localparam int CW         = $clog2(BIT_CLKS),
  localparam int DEV_W      = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      pkt_gs,
  output logic [DEV_W-1:0] rd_dev,
  output seq_state_t       state_o,
  output logic [CW-1:0]    cyc_o,
  output logic             bit_o,
  output logic             busy,
  output logic             done
);
  localparam int EOS_CLKS = EOS_BITS * BIT_CLKS;
  localparam int LAT_CLKS = LATCH_BITS * BIT_CLKS;
  localparam int GAP_MAX  = (EOS_CLKS > LAT_CLKS) ? EOS_CLKS : LAT_CLKS;
  localparam int GW       = $clog2(GAP_MAX);

  localparam logic [CW-1:0]    CYC_LAST = CW'(BIT_CLKS - 1);
  localparam logic [GW-1:0]    EOS_LAST = GW'(EOS_CLKS - 1);
  localparam logic [GW-1:0]    LAT_LAST = GW'(LAT_CLKS - 1);
  localparam logic [DEV_W-1:0] DEV_LAST = DEV_W'(N_DEV - 1);
  localparam logic [4:0]       BIT_LAST = 5'(PKT_BITS - 1);

  seq_state_t     state_q, state_d;
  logic [CW-1:0]  cyc_q, cyc_d;
  logic [4:0]     bit_q, bit_d;
  logic [DEV_W-1:0] dev_q, dev_d;
  logic [GW-1:0]  gap_q, gap_d;
  logic [31:0]    shreg_q, shreg_d;
  logic           done_q, done_d;
  logic           shreg_en;

  // next word source: device 0 from idle, else the following device
  assign rd_dev = (state_q == ST_IDLE) ? '0 : dev_q + DEV_W'(1);

  always_comb begin
    state_d  = state_q;
    cyc_d    = cyc_q;
    bit_d    = bit_q;
    dev_d    = dev_q;
    gap_d    = gap_q;
    shreg_d  = shreg_q;
    shreg_en = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_SEND;
          cyc_d    = '0;
          bit_d    = '0;
          dev_d    = '0;
          shreg_d  = {CMD_BYTE, pkt_gs};
          shreg_en = 1'b1;
        end
      end
      ST_SEND: begin
        if (cyc_q == CYC_LAST) begin
          cyc_d = '0;
          if (bit_q == BIT_LAST) begin
            gap_d   = '0;
            state_d = (dev_q == DEV_LAST) ? ST_LATCH : ST_EOS;
          end else begin
            bit_d    = bit_q + 5'd1;
            shreg_d  = {shreg_q[30:0], 1'b0};
            shreg_en = 1'b1;
          end
        end else begin
          cyc_d = cyc_q + CW'(1);
        end
      end
      ST_EOS: begin
        if (gap_q == EOS_LAST) begin
          state_d  = ST_SEND;
          dev_d    = dev_q + DEV_W'(1);
          bit_d    = '0;
          cyc_d    = '0;
          shreg_d  = {CMD_BYTE, pkt_gs};
          shreg_en = 1'b1;
        end else begin
          gap_d = gap_q + GW'(1);
        end
      end
      ST_LATCH: begin
        if (gap_q == LAT_LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          gap_d = gap_q + GW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      bit_q   <= '0;
      dev_q   <= '0;
      gap_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cyc_q   <= cyc_d;
      bit_q   <= bit_d;
      dev_q   <= dev_d;
      gap_q   <= gap_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else if (shreg_en) begin
      shreg_q <= shreg_d;
    end
  end

  assign state_o = state_q;
  assign cyc_o   = cyc_q;
  assign bit_o   = shreg_q[31];
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
endmodule

// File: rtl/ledchain_tx.sv
module ledchain_tx
  import ledchain_pkg::*;
#(
  parameter  int N_DEV      = 4,
  parameter  int BIT_CLKS   = 16,
  parameter  int EOS_BITS   = 4,
  parameter  int LATCH_BITS = 8,
  localparam int DEV_W      = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic [DEV_W-1:0] ld_dev,
  input  logic [1:0]       ld_ch,
  input  logic [7:0]       ld_val,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             sdo
);
  localparam int CW = $clog2(BIT_CLKS);

  logic             rst_meta, rst_sync_n;
  logic             wr_ok;
  logic [DEV_W-1:0] rd_dev;
  logic [23:0]      rd_word;
  seq_state_t       seq_st;
  logic [CW-1:0]    seq_cyc;
  logic             seq_bit;
  logic             line_d;
  logic             sdo_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign wr_ok = ld_we && !busy;

  ledchain_gs_store #(.N_DEV(N_DEV)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (wr_ok),
    .wr_dev  (ld_dev),
    .wr_ch   (ld_ch),
    .wr_val  (ld_val),
    .rd_dev  (rd_dev),
    .rd_word (rd_word)
  );

  ledchain_seq #(
    .N_DEV      (N_DEV),
    .BIT_CLKS   (BIT_CLKS),
    .EOS_BITS   (EOS_BITS),
    .LATCH_BITS (LATCH_BITS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .pkt_gs  (rd_word),
    .rd_dev  (rd_dev),
    .state_o (seq_st),
    .cyc_o   (seq_cyc),
    .bit_o   (seq_bit),
    .busy    (busy),
    .done    (done)
  );

  ledchain_bit_shaper #(.BIT_CLKS(BIT_CLKS)) u_shaper (
    .sending (seq_st == ST_SEND),
    .cyc     (seq_cyc),
    .bit_val (seq_bit),
    .line    (line_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
    end else begin
      sdo_q <= line_d;
    end
  end

  assign sdo = sdo_q;
endmodule

// File: rtl/ledchain_tx_chk.sv
module ledchain_tx_chk
  import ledchain_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       sdo,
  input seq_state_t st
);
  // R6: done lasts a single clock
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: done coincides with the end of busy
  p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7: busy only rises after a sampled start
  p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R5: the end-of-word gap keeps the line low
  p_gap_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EOS) |=> !sdo);

  // R1: an idle sequencer keeps the line low
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> !sdo);

  // R8: start during a transfer does not end it early
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && st != ST_LATCH) |=> busy);
endmodule

bind ledchain_tx ledchain_tx_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .sdo   (sdo),
  .st    (seq_st)
);

// File: tb/ledchain_tx_bench.sv
`timescale 1ns/1ps
module ledchain_tx_bench;
  localparam int N    = 3;
  localparam int T    = 16;
  localparam int PW   = T / 8;
  localparam int QTR  = T / 4;
  localparam int DW   = 2;
  localparam int MAXR = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_we = 1'b0;
  logic [DW-1:0] ld_dev = '0;
  logic [1:0]    ld_ch = '0;
  logic [7:0]    ld_val = '0;
  logic          start = 1'b0;
  logic          busy, done, sdo;

  ledchain_tx #(.N_DEV(N), .BIT_CLKS(T)) u_ledchain_tx (
    .clk (clk), .rst_n (rst_n), .ld_we (ld_we), .ld_dev (ld_dev),
    .ld_ch (ld_ch), .ld_val (ld_val), .start (start),
    .busy (busy), .done (done), .sdo (sdo)
  );

  always #2.5 clk = ~clk;

  int nvec = 0;
  int nfail = 0;
  int ncyc = 0;
  int rises [MAXR];
  int nr = 0;
  int hi_t = 0;
  int bad_w = 0;
  int ndone = 0;
  int done_t = 0;
  int st_t = 0;
  logic sdo_prev = 1'b0;
  logic [7:0] model [N][3];

  always @(posedge clk) ncyc <= ncyc + 1;

  always @(negedge clk) begin
    if (sdo && !sdo_prev) begin
      if (nr < MAXR) rises[nr] = ncyc;
      nr++;
      hi_t = ncyc;
    end
    if (!sdo && sdo_prev && (ncyc - hi_t != PW)) bad_w++;
    if (done) begin
      ndone++;
      done_t = ncyc;
    end
    sdo_prev = sdo;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (ncyc > 190000) begin
      nfail++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  task automatic load(input int d, input int c, input int v);
    @(negedge clk);
    ld_we = 1'b1; ld_dev = DW'(d); ld_ch = 2'(c); ld_val = 8'(v);
    if (!busy && c < 3) model[d][c] = 8'(v);
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  function automatic logic [31:0] expw(input int d);
    return {8'h3A, model[d][2], model[d][1], model[d][0]};
  endfunction

  function automatic int rise_at(input int p);
    return (p < nr && p < MAXR) ? rises[p] : -1;
  endfunction

  task automatic run_frame(input bit mid_start, input bit mid_load);
    int waited;
    int p;
    int t0;
    int bad_iv;
    logic [31:0] w;
    nr = 0; ndone = 0; bad_w = 0;
    @(negedge clk);
    start = 1'b1; st_t = ncyc;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R7 busy after start", busy, 1);
    if (mid_start) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (mid_load) begin
      // R9: write while busy must not reach the stored values
      repeat (100) @(negedge clk);
      ld_we = 1'b1; ld_dev = DW'(1); ld_ch = 2'd0; ld_val = ~model[1][0];
      @(negedge clk);
      ld_we = 1'b0;
    end
    waited = 0;
    while (ndone == 0 && waited < 20000) begin
      @(negedge clk); #1;
      waited++;
    end
    chk(ndone != 0, "R6 done seen", ndone, 1);
    repeat (40) @(negedge clk);
    chk(ndone == 1, "R8 single done pulse", ndone, 1);
    chk(busy === 1'b0 && sdo === 1'b0, "R6 idle after done", {busy, sdo}, 0);
    chk(rise_at(0) == st_t + 2, "R7 first edge", rise_at(0), st_t + 2);
    p = 0; bad_iv = 0;
    for (int d = 0; d < N; d++) begin
      w = '0;
      for (int b = 0; b < 32; b++) begin
        t0 = rise_at(p);
        if (rise_at(p + 1) == t0 + QTR) begin
          w = {w[30:0], 1'b1}; p += 2;
        end else begin
          w = {w[30:0], 1'b0}; p += 1;
        end
        if (b < 31) begin
          if (rise_at(p) - t0 != T) bad_iv++;
        end else if (d < N - 1) begin
          chk(rise_at(p) - t0 == 5 * T, "R5 gap spacing", rise_at(p) - t0, 5 * T);
        end else begin
          chk(done_t - t0 == 9 * T - 1, "R6 latch gap", done_t - t0, 9 * T - 1);
        end
      end
      chk(w == expw(d), "R2 R4 device word", w, expw(d));
    end
    chk(bad_iv == 0, "R3 bit spacing", bad_iv, 0);
    chk(bad_w == 0, "R3 pulse width", bad_w, 0);
    chk(p == nr, "R10 total edges", nr, p);
  endtask

  initial begin
    for (int d = 0; d < N; d++)
      for (int c = 0; c < 3; c++) model[d][c] = 8'h00;
    repeat (3) @(negedge clk);
    chk(sdo === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 reset outputs", {sdo, busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdo === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 after release", {sdo, busy, done}, 0);
    // R1: stored values start at zero
    run_frame(1'b0, 1'b0);
    for (int d = 0; d < N; d++)
      for (int c = 0; c < 3; c++) load(d, c, 255);
    run_frame(1'b0, 1'b0);
    // R9 R2 sweep over value patterns
    for (int k = 0; k < 24; k++) begin
      for (int d = 0; d < N; d++)
        for (int c = 0; c < 3; c++)
          load(d, c, (k < 8) ? (1 << ((d * 3 + c + k) % 8)) : ((d * 53 + c * 29 + k * 41) % 256));
      run_frame(1'b0, 1'b0);
    end
    // R10: repeat with no change
    run_frame(1'b0, 1'b0);
    // R8 R9: start and load during busy
    run_frame(1'b1, 1'b1);
    run_frame(1'b0, 1'b0);
    // R9: channel 3 writes nothing
    load(2, 3, 8'h5A);
    load(0, 3, 8'hC3);
    run_frame(1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule